// File: doc/BRIEF.md
# Nine-Level Stacked-Carrier PWM Modulator

This block turns a signed, sampled sinusoidal reference into a nine-level switching state for an output stage built from two series-connected five-level cells. A single up/down counter forms a triangular carrier. Eight copies of it are offset by whole multiples of the carrier height, so that their bands stack without gaps around zero. On every clock the reference is compared against all eight copies. The number of copies that the reference exceeds is the switching state.

The state is registered and presented in three forms: the raw state 0..8, the signed output level in units of the cell step, and one command per cell in the range -2..+2. The two cell commands always add up to the total level. The carrier half-period is taken from an input while the block is disabled. While the enable is low, the block drives a zero output.

Top module: `lsc_pwm_mod`

## Requirements
- R1: The carrier counter value c and the latched half-period P (P at least 1) define eight carriers. Carrier k (k = 0..7) equals c + (k-4)*P. A carrier counts as exceeded only when the reference is strictly greater than it, so equality counts as not exceeded.
- R2: `state_o` equals the number of exceeded carriers (0..8). It appears at the clock edge that follows the cycle in which the reference and the counter were compared.
- R3: `level_o` is the two's-complement value `state_o` - 4, in the range -4..+4.
- R4: `cell1_o` is the level clamped to -2..+2, and `cell2_o` is the level minus `cell1_o`. Both commands are two's-complement, and their sum equals `level_o`.
- R5: After the enable rises, the counter starts at 0 and counts up by one per clock to P, then down by one per clock to 0, then repeats. One period is 2*P clocks.
- R6: While `en_i` is low at a clock edge, that edge sets `state_o` = 4 and the level and both cell commands to 0. It also returns the counter to 0, counting up.
- R7: `period_i` is captured only on edges where `en_i` is low. Changes to it while the block is enabled have no effect on the outputs.
- R8: During reset the outputs show `state_o` = 4, with the level and both cell commands at 0.
- R9: A reference of +4P gives state 8, except in the cycle where c = P, which gives 7. A reference of -4P always gives state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Modulator enable; while low, the output is forced to zero |
| period_i | input | PER_W | Carrier half-period P in clocks, captured while disabled |
| ref_i | input | PER_W+4 | Signed reference sample, range -4P..+4P |
| state_o | output | 4 | Switching state 0..8 |
| level_o | output | 4 | Signed output level -4..+4 |
| cell1_o | output | 3 | Signed command for cell one, -2..+2 |
| cell2_o | output | 3 | Signed command for cell two, -2..+2 |

## Verification
The bench drives a reference that sits exactly on a carrier. A design that compares with greater-or-equal instead of strictly greater reports a state one step too high there. It also holds the reference at the full-scale values ±4P, where an off-by-one error in a carrier offset or at the counter turning point shows up as a wrong state in the peak cycle. Other runs drop the enable in the middle of a period and change the period while the block is enabled. A design that keeps the counter phase through a disable, or that follows a live period input, loses step with the cycle-by-cycle prediction. Sweeps at P = 1 and P = 4 exercise every level, which exposes a cell split that does not add up or does not clamp at ±2.

// File: rtl/lsc_pwm_pkg.sv
package lsc_pwm_pkg;
  localparam int N_CARR   = 8;
  localparam int MID_ST   = N_CARR / 2;
  localparam int ST_W     = $clog2(N_CARR + 1);
  localparam int CELL_MAX = 2;

  typedef logic        [ST_W-1:0] state_t;
  typedef logic signed [3:0]      level_t;
  typedef logic signed [2:0]      cell_t;

  typedef struct packed {
    state_t st;
    level_t lvl;
    cell_t  c1;
    cell_t  c2;
  } mod_out_t;

  localparam mod_out_t ZERO_OUT = '{st: ST_W'(MID_ST), lvl: '0, c1: '0, c2: '0};
endpackage

// File: rtl/lsc_tri_counter.sv
module lsc_tri_counter #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] per_i,
  output logic [PER_W-1:0] cnt_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic [PER_W:0]   inc;

  assign inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!en_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (up_q) begin
      cnt_d = inc[PER_W-1:0];
      up_d  = !(inc >= {1'b0, per_i});
    end else begin
      cnt_d = cnt_q - 1'b1;
      up_d  = (cnt_q <= PER_W'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lsc_cmp_bank.sv
module lsc_cmp_bank
  import lsc_pwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int REF_W = PER_W + 4
) (
  input  logic                    [PER_W-1:0] cnt_i,
  input  logic                    [PER_W-1:0] per_i,
  input  logic signed             [REF_W-1:0] ref_i,
  output state_t                              count_o
);
  logic signed [REF_W-1:0] cnt_s, per_s;
  logic        [N_CARR-1:0] hit;

  assign cnt_s = signed'({{(REF_W-PER_W){1'b0}}, cnt_i});
  assign per_s = signed'({{(REF_W-PER_W){1'b0}}, per_i});

  for (genvar k = 0; k < N_CARR; k++) begin : g_carr
    localparam logic signed [REF_W-1:0] KOFF = REF_W'(k - MID_ST);
    logic signed [REF_W-1:0] carrier;
    assign carrier = cnt_s + KOFF * per_s;
    assign hit[k]  = (ref_i > carrier);
  end

  always_comb begin
    count_o = '0;
    for (int k = 0; k < N_CARR; k++) begin
      count_o = count_o + ST_W'(hit[k]);
    end
  end
endmodule

// File: rtl/lsc_level_map.sv
module lsc_level_map
  import lsc_pwm_pkg::*;
(
  input  state_t   st_i,
  output mod_out_t out_o
);
  level_t lvl;
  cell_t  c1;

  assign lvl = level_t'(st_i) - level_t'(MID_ST);

  always_comb begin
    if (lvl > level_t'(CELL_MAX))       c1 = cell_t'(CELL_MAX);
    else if (lvl < -level_t'(CELL_MAX)) c1 = -cell_t'(CELL_MAX);
    else                                c1 = cell_t'(lvl);
  end

  assign out_o.st  = st_i;
  assign out_o.lvl = lvl;
  assign out_o.c1  = c1;
  assign out_o.c2  = cell_t'(lvl - level_t'(c1));
endmodule

// File: rtl/lsc_pwm_mod.sv
module lsc_pwm_mod
  import lsc_pwm_pkg::*;
#(
  parameter  int PER_W = 8,
  localparam int REF_W = PER_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PER_W-1:0]        period_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [3:0]              state_o,
  output logic signed [3:0]       level_o,
  output logic signed [2:0]       cell1_o,
  output logic signed [2:0]       cell2_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [PER_W-1:0] p_q, p_d;
  logic [PER_W-1:0] cnt_w;
  state_t           count_w;
  mod_out_t         map_w, out_q, out_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign p_d = en_i ? p_q : period_i;

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) p_q <= '0;
    else            p_q <= p_d;
  end

  lsc_tri_counter #(.PER_W(PER_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (en_i),
    .per_i  (p_q),
    .cnt_o  (cnt_w)
  );

  lsc_cmp_bank #(.PER_W(PER_W), .REF_W(REF_W)) u_cmp (
    .cnt_i   (cnt_w),
    .per_i   (p_q),
    .ref_i   (ref_i),
    .count_o (count_w)
  );

  lsc_level_map u_map (
    .st_i  (count_w),
    .out_o (map_w)
  );

  assign out_d = en_i ? map_w : ZERO_OUT;

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= ZERO_OUT;
    else            out_q <= out_d;
  end

  assign state_o = 4'(out_q.st);
  assign level_o = out_q.lvl;
  assign cell1_o = out_q.c1;
  assign cell2_o = out_q.c2;
endmodule

// File: rtl/lsc_pwm_mod_chk.sv
module lsc_pwm_mod_chk #(
  parameter int PER_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [PER_W-1:0]        p_q,
  input logic [PER_W-1:0]        cnt_w,
  input logic [3:0]              state_o,
  input logic signed [3:0]       level_o,
  input logic signed [2:0]       cell1_o,
  input logic signed [2:0]       cell2_o
);
  logic signed [4:0] cell_sum;
  logic signed [4:0] lvl_ext;
  assign cell_sum = cell1_o + cell2_o;
  assign lvl_ext  = level_o;

  assert_state_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd8);

  assert_level_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == signed'(state_o) - 4'sd4);

  assert_cell_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_sum == lvl_ext);

  assert_cell_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell2_o != 3'sd0) |-> (cell1_o == (cell2_o > 3'sd0 ? 3'sd2 : -3'sd2)));

  assert_disable_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_o == 4'd4 && cell1_o == 3'sd0 && cell2_o == 3'sd0));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w <= p_q) || (p_q == '0));

  assert_period_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> $stable(p_q));
endmodule

bind lsc_pwm_mod lsc_pwm_mod_chk #(.PER_W(PER_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .p_q     (p_q),
  .cnt_w   (cnt_w),
  .state_o (state_o),
  .level_o (level_o),
  .cell1_o (cell1_o),
  .cell2_o (cell2_o)
);

// File: tb/lsc_pwm_mod_bench.sv
`timescale 1ns/1ps
module lsc_pwm_mod_bench;
  localparam int PER_W = 8;
  localparam int REF_W = PER_W + 4;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    en;
  logic [PER_W-1:0]        period;
  logic signed [REF_W-1:0] refv;
  logic [3:0]              state_o;
  logic signed [3:0]       level_o;
  logic signed [2:0]       cell1_o, cell2_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lsc_pwm_mod #(.PER_W(PER_W)) u_lsc_pwm_mod (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period), .ref_i(refv),
    .state_o(state_o), .level_o(level_o), .cell1_o(cell1_o), .cell2_o(cell2_o)
  );

  // Prediction model built from the requirements
  int m_cnt, m_p, exp_s, s;
  logic m_up;
  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_cnt <= 0; m_up <= 1'b1; m_p <= int'(period); exp_s <= 4;
    end else begin
      s = 0;
      for (int k = 0; k < 8; k++)
        if (int'(refv) > m_cnt + (k - 4) * m_p) s++;
      exp_s <= s;
      if (m_up) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt + 1 >= m_p) m_up <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
        if (m_cnt <= 1) m_up <= 1'b1;
      end
    end
  end

  task automatic chk(string tag);
    int el, e1, e2;
    el = exp_s - 4;
    e1 = (el > 2) ? 2 : (el < -2) ? -2 : el;
    e2 = el - e1;
    checks++;
    if (int'(state_o) != exp_s || int'(level_o) != el ||
        int'(cell1_o) != e1 || int'(cell2_o) != e2) begin
      failures++;
      $display("FAIL %s: got st=%0d lvl=%0d c1=%0d c2=%0d exp st=%0d lvl=%0d c1=%0d c2=%0d",
               tag, state_o, level_o, cell1_o, cell2_o, exp_s, el, e1, e2);
    end
  endtask

  task automatic chk_val(string tag, int got, int expv);
    checks++;
    if (got != expv) begin
      failures++;
      $display("FAIL %s: got %0d exp %0d", tag, got, expv);
    end
  endtask

  task automatic disable_load(int p);
    @(negedge clk); en = 1'b0; period = PER_W'(p);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; period = '0; refv = '0;
    repeat (3) @(negedge clk);
    chk_val("R8 reset state", int'(state_o), 4);
    chk_val("R8 reset level", int'(level_o), 0);
    chk_val("R8 reset cells", int'(cell1_o) + 10 * int'(cell2_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_equal();
    disable_load(4);
    refv = '0; en = 1'b1;
    @(negedge clk);
    chk_val("R1 equal to carrier counts as not greater", int'(state_o), 4);
    refv = 12'sd1;
    @(negedge clk);
    chk("R1 R2 just above carrier");
    for (int i = 0; i < 20; i++) begin
      refv = REF_W'(i % 3);
      @(negedge clk); chk("R1 R2 R5 near zero");
    end
  endtask

  task automatic t_sweep(int p);
    disable_load(p);
    en = 1'b1;
    for (int i = 0; i < 160; i++) begin
      int v;
      v = (i % (16 * p + 1)) - 8 * p;
      if ((i / (16 * p + 1)) % 2 == 1) v = -v;
      refv = REF_W'(v);
      @(negedge clk); chk("R2 R3 R4 R5 sweep");
    end
  endtask

  task automatic t_extremes();
    int peak_seen;
    peak_seen = 0;
    disable_load(4);
    refv = 12'sd16; en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); chk("R9 ref at +4P");
      if (state_o == 4'd7) peak_seen++;
    end
    chk_val("R9 +4P drops to 7 once per period", peak_seen, 2);
    refv = -12'sd16;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); chk_val("R9 ref at -4P", int'(state_o), 0);
    end
  endtask

  task automatic t_disable();
    disable_load(3);
    refv = 12'sd5; en = 1'b1;
    repeat (4) begin @(negedge clk); chk("R5 before disable"); end
    en = 1'b0;
    @(negedge clk);
    chk_val("R6 disabled state", int'(state_o), 4);
    chk_val("R6 disabled cells", int'(cell1_o) + 10 * int'(cell2_o), 0);
    en = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); chk("R5 R6 restart from zero");
    end
  endtask

  task automatic t_period_ignore();
    disable_load(3);
    refv = 12'sd2; en = 1'b1;
    repeat (3) @(negedge clk);
    period = PER_W'(7);
    for (int i = 0; i < 24; i++) begin
      refv = REF_W'((i % 9) - 4);
      @(negedge clk); chk("R7 live period change ignored");
    end
  endtask

  initial begin
    t_reset();
    t_equal();
    t_sweep(4);
    t_sweep(1);
    t_extremes();
    t_disable();
    t_period_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule